// File: doc/BRIEF.md
# Capability Memory Operand Authorizer

This block sits between address generation and the data memory pipeline. For every data access it decides which capability grants the access: the default data capability, the current code capability, or the capability held in the operand's base register. It then checks the access against that capability. It receives the class of the memory operand, the effective address, the access size in bytes, the direction (load or store), a global capability-mode flag and a one-instruction prefix flag that inverts the mode's default addressing. It returns the virtual address unchanged, a code naming the selected authority and a fault code.

Integer addresses are absolute. They are only bounds-checked against the selected capability and are never relocated by its base. The decision is combinational. An optional output register stage, selected by a parameter, is enabled by default.

Top module: `cap_mem_auth`

## Requirements
- R1: The addressing in effect is capability-aware when exactly one of capability mode and the inverting prefix is set, and plain otherwise. Plain addressing always selects the default data capability (authority code 0).
- R2: A register-based operand (class 0) under capability-aware addressing selects the base-register capability (authority code 2). Under plain addressing it selects the default data capability.
- R3: An instruction-pointer-relative operand (class 1) selects the code capability (authority code 1) under capability-aware addressing and the default data capability under plain addressing.
- R4: An operand with no base register (class 2), and the unused class 3, select the default data capability in both modes and with or without the prefix.
- R5: The address output equals the input address. It is never offset by any capability base.
- R6: A selected capability whose tag is clear yields fault code 1.
- R7: Permission bit 0 grants loads and bit 1 grants stores. An access whose direction lacks its bit on the selected capability yields fault code 2.
- R8: Bounds hold when base <= address and address + size <= top. Top is 65 bits wide and the sum is formed without wrapping. Any other case yields fault code 3. When no condition applies the fault code is 0.
- R9: When several faults apply, the tag fault wins over the permission fault, and the permission fault wins over the bounds fault.
- R10: With the output stage enabled, every output reflects the inputs sampled at the previous rising clock edge and holds until the next edge. During reset the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode_i | input | 1 | Capability mode is active |
| flip_pfx_i | input | 1 | Inverting prefix present on this instruction |
| opclass_i | input | 2 | Operand class: 0 register-based, 1 instruction-pointer-relative, 2 no base register |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| addr_i | input | 64 | Effective virtual address |
| size_i | input | 5 | Access size in bytes |
| data_tag_i | input | 1 | Default data capability tag |
| data_base_i | input | 64 | Default data capability base |
| data_top_i | input | 65 | Default data capability top (exclusive) |
| data_perm_i | input | 2 | Default data capability permissions |
| code_tag_i | input | 1 | Code capability tag |
| code_base_i | input | 64 | Code capability base |
| code_top_i | input | 65 | Code capability top (exclusive) |
| code_perm_i | input | 2 | Code capability permissions |
| breg_tag_i | input | 1 | Base-register capability tag |
| breg_base_i | input | 64 | Base-register capability base |
| breg_top_i | input | 65 | Base-register capability top (exclusive) |
| breg_perm_i | input | 2 | Base-register capability permissions |
| vaddr_o | output | 64 | Virtual address passed through |
| auth_src_o | output | 2 | Authority: 0 default data, 1 code, 2 base register |
| fault_o | output | 2 | 0 none, 1 tag, 2 permission, 3 bounds |

## Verification
With the output stage enabled, the address, authority and fault for a stimulus are due one rising edge after the stimulus is applied. Until that edge the outputs keep the result of the previous stimulus. The bench applies each stimulus just after a falling edge and computes its expected result at once. It confirms one nanosecond later that the outputs still show the previous result. At the next falling edge, after exactly one rising edge, it compares all three outputs with the new expectation. The concurrent properties use the same one-cycle offset through non-overlapping implication.

// File: rtl/cap_auth_pkg.sv
package cap_auth_pkg;

    localparam int unsigned ADDR_W      = 64;
    localparam int unsigned TOP_W       = ADDR_W + 1;
    localparam int unsigned SIZE_W      = 5;
    localparam int unsigned PERM_W      = 2;
    localparam int unsigned PERM_LD_BIT = 0;
    localparam int unsigned PERM_ST_BIT = 1;

    typedef enum logic [1:0] {
        OPC_REG   = 2'd0,
        OPC_IPREL = 2'd1,
        OPC_ABS   = 2'd2,
        OPC_RSVD  = 2'd3
    } opclass_e;

    typedef enum logic [1:0] {
        SRC_DATA    = 2'd0,
        SRC_CODE    = 2'd1,
        SRC_BASEREG = 2'd2
    } auth_src_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_TAG    = 2'd1,
        FLT_PERM   = 2'd2,
        FLT_BOUNDS = 2'd3
    } fault_e;

    typedef struct packed {
        logic              tag;
        logic [ADDR_W-1:0] base;
        logic [TOP_W-1:0]  top;
        logic [PERM_W-1:0] perm;
    } cap_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vaddr;
        auth_src_e         src;
        fault_e            fault;
    } verdict_t;

endpackage

// File: rtl/cap_auth_select.sv
module cap_auth_select
    import cap_auth_pkg::*;
(
    input  logic      cap_mode_i,
    input  logic      flip_pfx_i,
    input  opclass_e  opclass_i,
    input  cap_t      data_cap_i,
    input  cap_t      code_cap_i,
    input  cap_t      breg_cap_i,
    output auth_src_e src_o,
    output cap_t      cap_o
);

    logic cap_aware;

    always_comb begin
        // the prefix inverts whatever the current mode makes the default
        cap_aware = cap_mode_i ^ flip_pfx_i;
        unique case (opclass_i)
            OPC_REG:   src_o = cap_aware ? SRC_BASEREG : SRC_DATA;
            OPC_IPREL: src_o = cap_aware ? SRC_CODE    : SRC_DATA;
            default:   src_o = SRC_DATA;
        endcase
        unique case (src_o)
            SRC_CODE:    cap_o = code_cap_i;
            SRC_BASEREG: cap_o = breg_cap_i;
            default:     cap_o = data_cap_i;
        endcase
    end

endmodule

// File: rtl/cap_access_check.sv
module cap_access_check
    import cap_auth_pkg::*;
(
    input  cap_t              cap_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              is_store_i,
    output fault_e            fault_o
);

    logic [TOP_W-1:0] end_addr;
    logic             perm_ok;
    logic             lo_ok;
    logic             hi_ok;

    always_comb begin
        // one extra bit keeps the end of the access from wrapping
        end_addr = {1'b0, addr_i} + TOP_W'(size_i);
        perm_ok  = is_store_i ? cap_i.perm[PERM_ST_BIT] : cap_i.perm[PERM_LD_BIT];
        lo_ok    = (addr_i >= cap_i.base);
        hi_ok    = (end_addr <= cap_i.top);
        if (!cap_i.tag) begin
            fault_o = FLT_TAG;
        end else if (!perm_ok) begin
            fault_o = FLT_PERM;
        end else if (!(lo_ok && hi_ok)) begin
            fault_o = FLT_BOUNDS;
        end else begin
            fault_o = FLT_NONE;
        end
    end

endmodule

// File: rtl/cap_mem_auth.sv
module cap_mem_auth
    import cap_auth_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_mode_i,
    input  logic              flip_pfx_i,
    input  logic [1:0]        opclass_i,
    input  logic              is_store_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              data_tag_i,
    input  logic [ADDR_W-1:0] data_base_i,
    input  logic [TOP_W-1:0]  data_top_i,
    input  logic [PERM_W-1:0] data_perm_i,
    input  logic              code_tag_i,
    input  logic [ADDR_W-1:0] code_base_i,
    input  logic [TOP_W-1:0]  code_top_i,
    input  logic [PERM_W-1:0] code_perm_i,
    input  logic              breg_tag_i,
    input  logic [ADDR_W-1:0] breg_base_i,
    input  logic [TOP_W-1:0]  breg_top_i,
    input  logic [PERM_W-1:0] breg_perm_i,
    output logic [ADDR_W-1:0] vaddr_o,
    output logic [1:0]        auth_src_o,
    output logic [1:0]        fault_o
);

    cap_t      data_cap;
    cap_t      code_cap;
    cap_t      breg_cap;
    cap_t      sel_cap;
    auth_src_e sel_src;
    fault_e    chk_fault;
    verdict_t  verdict_d;
    verdict_t  verdict_q;

    always_comb begin
        data_cap = '{tag: data_tag_i, base: data_base_i, top: data_top_i, perm: data_perm_i};
        code_cap = '{tag: code_tag_i, base: code_base_i, top: code_top_i, perm: code_perm_i};
        breg_cap = '{tag: breg_tag_i, base: breg_base_i, top: breg_top_i, perm: breg_perm_i};
    end

    cap_auth_select u_select (
        .cap_mode_i (cap_mode_i),
        .flip_pfx_i (flip_pfx_i),
        .opclass_i  (opclass_e'(opclass_i)),
        .data_cap_i (data_cap),
        .code_cap_i (code_cap),
        .breg_cap_i (breg_cap),
        .src_o      (sel_src),
        .cap_o      (sel_cap)
    );

    cap_access_check u_check (
        .cap_i      (sel_cap),
        .addr_i     (addr_i),
        .size_i     (size_i),
        .is_store_i (is_store_i),
        .fault_o    (chk_fault)
    );

    always_comb begin
        verdict_d.vaddr = addr_i;
        verdict_d.src   = sel_src;
        verdict_d.fault = chk_fault;
    end

    generate
        if (OUT_REG) begin : g_out_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    verdict_q <= '0;
                end else begin
                    verdict_q <= verdict_d;
                end
            end
        end else begin : g_out_comb
            always_comb verdict_q = verdict_d;
        end
    endgenerate

    assign vaddr_o    = verdict_q.vaddr;
    assign auth_src_o = verdict_q.src;
    assign fault_o    = verdict_q.fault;

endmodule

// File: rtl/cap_mem_auth_sva.sv
module cap_mem_auth_sva
    import cap_auth_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_mode_i,
    input logic              flip_pfx_i,
    input logic [1:0]        opclass_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              data_tag_i,
    input logic              code_tag_i,
    input logic              breg_tag_i,
    input logic [ADDR_W-1:0] vaddr_o,
    input logic [1:0]        auth_src_o,
    input logic [1:0]        fault_o
);

    logic aware;
    assign aware = cap_mode_i ^ flip_pfx_i;

    generate
        if (OUT_REG) begin : g_seq
            AST_PLAIN_USES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                !aware |=> auth_src_o == 2'd0); // R1
            AST_BASEREG_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
                (aware && opclass_i == 2'd0) |=> auth_src_o == 2'd2); // R2
            AST_IPREL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
                (aware && opclass_i == 2'd1) |=> auth_src_o == 2'd1); // R3
            AST_NOBASE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                (opclass_i[1]) |=> auth_src_o == 2'd0); // R4
            AST_VADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> vaddr_o == $past(addr_i)); // R5
            AST_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                (!data_tag_i && !code_tag_i && !breg_tag_i) |=> fault_o == 2'd1); // R9
        end else begin : g_comb
            AST_PLAIN_USES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                !aware |-> auth_src_o == 2'd0); // R1
            AST_BASEREG_AUTH: assert property (@(posedge clk) disable iff (!rst_n)
                (aware && opclass_i == 2'd0) |-> auth_src_o == 2'd2); // R2
            AST_IPREL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
                (aware && opclass_i == 2'd1) |-> auth_src_o == 2'd1); // R3
            AST_NOBASE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                (opclass_i[1]) |-> auth_src_o == 2'd0); // R4
            AST_VADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                vaddr_o == addr_i); // R5
            AST_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
                (!data_tag_i && !code_tag_i && !breg_tag_i) |-> fault_o == 2'd1); // R9
        end
    endgenerate

endmodule

bind cap_mem_auth cap_mem_auth_sva #(.OUT_REG(OUT_REG)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode_i (cap_mode_i),
    .flip_pfx_i (flip_pfx_i),
    .opclass_i  (opclass_i),
    .addr_i     (addr_i),
    .data_tag_i (data_tag_i),
    .code_tag_i (code_tag_i),
    .breg_tag_i (breg_tag_i),
    .vaddr_o    (vaddr_o),
    .auth_src_o (auth_src_o),
    .fault_o    (fault_o)
);

// File: tb/sim_cap_mem_auth.sv
module sim_cap_mem_auth;
    import cap_auth_pkg::*;

    localparam int AW = ADDR_W;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              cap_mode, pfx, st;
    logic [1:0]        opc;
    logic [AW-1:0]     addr;
    logic [SIZE_W-1:0] size;
    logic              d_tag, c_tag, r_tag;
    logic [AW-1:0]     d_base, c_base, r_base;
    logic [AW:0]       d_top, c_top, r_top;
    logic [1:0]        d_perm, c_perm, r_perm;
    logic [AW-1:0]     vaddr_o;
    logic [1:0]        auth_src_o, fault_o;

    cap_mem_auth u0 (
        .clk(clk), .rst_n(rst_n), .cap_mode_i(cap_mode), .flip_pfx_i(pfx),
        .opclass_i(opc), .is_store_i(st), .addr_i(addr), .size_i(size),
        .data_tag_i(d_tag), .data_base_i(d_base), .data_top_i(d_top), .data_perm_i(d_perm),
        .code_tag_i(c_tag), .code_base_i(c_base), .code_top_i(c_top), .code_perm_i(c_perm),
        .breg_tag_i(r_tag), .breg_base_i(r_base), .breg_top_i(r_top), .breg_perm_i(r_perm),
        .vaddr_o(vaddr_o), .auth_src_o(auth_src_o), .fault_o(fault_o)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] exp_va, prev_va;
    logic [1:0]    exp_src, prev_src, exp_flt, prev_flt;

    // behavioural reference: returns {authority, fault}
    function automatic logic [3:0] model();
        bit aware;
        int src;
        logic        tg;
        logic [AW:0] bs, tp, last;
        logic [1:0]  pm;
        bit allowed;
        aware = (cap_mode != pfx);
        if (opc == 2'd0 && aware)      src = 2;
        else if (opc == 2'd1 && aware) src = 1;
        else                           src = 0;
        case (src)
            1:       begin tg = c_tag; bs = {1'b0, c_base}; tp = c_top; pm = c_perm; end
            2:       begin tg = r_tag; bs = {1'b0, r_base}; tp = r_top; pm = r_perm; end
            default: begin tg = d_tag; bs = {1'b0, d_base}; tp = d_top; pm = d_perm; end
        endcase
        last = {1'b0, addr} + {{(AW+1-SIZE_W){1'b0}}, size};
        allowed = st ? pm[1] : pm[0];
        if (!tg)                                  return {src[1:0], 2'd1};
        else if (!allowed)                        return {src[1:0], 2'd2};
        else if ({1'b0, addr} < bs || last > tp)  return {src[1:0], 2'd3};
        else                                      return {src[1:0], 2'd0};
    endfunction

    task automatic check(string req, logic [AW-1:0] va, logic [1:0] s, logic [1:0] f);
        n_run++;
        if (vaddr_o !== va || auth_src_o !== s || fault_o !== f) begin
            n_fail++;
            $display("FAIL %s: got vaddr=%h src=%0d fault=%0d, expected vaddr=%h src=%0d fault=%0d",
                     req, vaddr_o, auth_src_o, fault_o, va, s, f);
        end
    endtask

    // inputs already set at a falling edge; result due after one rising edge
    task automatic step(string req);
        logic [3:0] r;
        string lbl;
        r = model();
        prev_va = exp_va; prev_src = exp_src; prev_flt = exp_flt;
        exp_va = addr; exp_src = r[3:2]; exp_flt = r[1:0];
        lbl = req;
        if (lbl == "") begin
            case (exp_flt)
                2'd1: lbl = "R6";
                2'd2: lbl = "R7";
                2'd3: lbl = "R8";
                default: lbl = (opc == 2'd1) ? "R3" : (opc == 2'd0) ? "R2" : "R4";
            endcase
        end
        #1 check("R10 hold", prev_va, prev_src, prev_flt);
        @(negedge clk);
        check(lbl, exp_va, exp_src, exp_flt);
    endtask

    task automatic caps_open();
        d_tag = 1; c_tag = 1; r_tag = 1;
        d_base = '0; c_base = '0; r_base = '0;
        d_top = {1'b1, {AW{1'b0}}}; c_top = d_top; r_top = d_top;
        d_perm = 2'b11; c_perm = 2'b11; r_perm = 2'b11;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cap_mode = 0; pfx = 0; st = 0; opc = 0; addr = '0; size = '0;
        d_tag = 0; c_tag = 0; r_tag = 0; d_base = '0; c_base = '0; r_base = '0;
        d_top = '0; c_top = '0; r_top = '0; d_perm = '0; c_perm = '0; r_perm = '0;
        exp_va = '0; exp_src = '0; exp_flt = '0;
        repeat (3) @(negedge clk);
        addr = 64'hDEAD; cap_mode = 1; #1;
        check("R10 reset", '0, 2'd0, 2'd0);
        @(negedge clk);
        check("R10 reset", '0, 2'd0, 2'd0);
        rst_n = 1;
        cap_mode = 0; addr = '0;

        caps_open();
        d_base = 64'h100; c_base = 64'h200; r_base = 64'h300;
        addr = 64'h1000; size = 8;

        // R1/R2 mode and prefix combinations on a register operand
        opc = 2'd0; cap_mode = 0; pfx = 0; step("R1 plain reg");
        cap_mode = 1; pfx = 0; step("R2 capmode reg");
        cap_mode = 1; pfx = 1; step("R1 capmode+prefix reg");
        cap_mode = 0; pfx = 1; step("R1 plain+prefix reg");

        // R3 instruction-pointer-relative
        opc = 2'd1; cap_mode = 0; pfx = 0; step("R3 plain iprel");
        cap_mode = 1; step("R3 capmode iprel");
        pfx = 1; step("R3 capmode+prefix iprel");

        // R4 no base register, all four combinations, and the unused class
        opc = 2'd2;
        for (int m = 0; m < 4; m++) begin
            cap_mode = m[0]; pfx = m[1]; step("R4 nobase");
        end
        opc = 2'd3; cap_mode = 1; pfx = 0; step("R4 unused class");

        // R5 address passes through unchanged with a nonzero base
        opc = 2'd2; cap_mode = 0; pfx = 0; d_base = 64'h4000; addr = 64'h4010;
        step("R5 no relocation");

        // R6 tag clear
        d_tag = 0; step("R6 tag clear");
        d_tag = 1;

        // R7 permissions
        d_base = '0; st = 0; d_perm = 2'b10; step("R7 load no perm");
        st = 1; d_perm = 2'b01; step("R7 store no perm");
        st = 1; d_perm = 2'b10; step("R7 store allowed");
        st = 0; d_perm = 2'b01; step("R7 load allowed");
        d_perm = 2'b11;

        // R8 bounds edges
        d_base = 64'h1000; d_top = 65'h1040;
        addr = 64'h1000; size = 8; step("R8 at base");
        addr = 64'h0FFF; size = 1; step("R8 below base");
        addr = 64'h1038; size = 8; step("R8 end at top");
        addr = 64'h1039; size = 8; step("R8 past top");
        d_base = '0; d_top = {1'b1, {AW{1'b0}}};
        addr = 64'hFFFF_FFFF_FFFF_FFF8; step("R8 top of space");
        addr = 64'hFFFF_FFFF_FFFF_FFF9; step("R8 wrap");

        // R9 priority
        d_top = 65'h10; addr = 64'h100; st = 1; d_perm = 2'b01; d_tag = 0;
        step("R9 tag over perm and bounds");
        d_tag = 1; step("R9 perm over bounds");
        d_perm = 2'b11; step("R9 bounds alone");

        // mixed patterns
        for (int i = 0; i < 400; i++) begin
            cap_mode = $urandom_range(0, 1); pfx = $urandom_range(0, 1);
            opc = 2'($urandom_range(0, 3)); st = $urandom_range(0, 1);
            size = SIZE_W'($urandom_range(1, 16));
            addr = 64'($urandom_range(0, 160));
            d_tag = ($urandom_range(0, 7) != 0); c_tag = ($urandom_range(0, 7) != 0);
            r_tag = ($urandom_range(0, 7) != 0);
            d_perm = 2'($urandom_range(0, 3)); c_perm = 2'($urandom_range(0, 3));
            r_perm = 2'($urandom_range(0, 3));
            d_base = 64'($urandom_range(0, 64)); c_base = 64'($urandom_range(0, 64));
            r_base = 64'($urandom_range(0, 64));
            d_top = {1'b0, d_base} + 65'($urandom_range(0, 96));
            c_top = {1'b0, c_base} + 65'($urandom_range(0, 96));
            r_top = {1'b0, r_base} + 65'($urandom_range(0, 96));
            step("");
        end

        finish_run();
    end

endmodule